// File: doc/BRIEF.md
# Transactional Line Conflict Tracker

This block follows the memory footprint of one core's hardware transaction, one cache line at a time. Between a begin strobe and an end strobe it keeps a fully associative table of line addresses. Each line carries a read mark and a write mark. Incoming coherence snoops are compared against the table to find conflicts. A conflict, a table overflow or a system event turns the end of the transaction into an abort. The cause is reported as a 2-bit code.

When the transaction finishes, the block pulses either commit or abort for one cycle. In the same cycle it presents a slot mask that names the table entries holding speculative writes. The data cache publishes those lines on commit and discards them on abort. After that the table is empty. The cache array, the register checkpoint and the coherence protocol live outside the block. They are seen only through the access, snoop and event ports.

Top module: `txn_line_tracker`

## Requirements
- R1: Addresses on the access and snoop ports are cache-line numbers. All accesses to one line number share a single table slot, so repeated or mixed loads and stores to a line use one entry.
- R2: While a transaction is active, a snooped invalidation (remote write or ownership request) that matches a line in the read set or the write set aborts it with cause 01 (conflict). This includes a writer taking a lock word that the transaction has read.
- R3: While active, a snooped remote read that matches a line in the write set aborts with cause 01. A remote read of a line that is only in the read set has no effect.
- R4: While active, a local access to a line that is not yet tracked, made when CAPACITY lines are already tracked, aborts with cause 10 (capacity). An access to an already tracked line never triggers this.
- R5: While active, an interrupt, page-fault or context-switch event aborts with cause 11 (system). Cause priority is system, then conflict, then capacity, then an explicit abort request, which reports cause 00.
- R6: An end strobe with no abort condition in the same cycle gives a one-cycle commit_o with cause 00. Slots are filled in order of first touch, so the n-th distinct line sits in slot n. In the commit cycle, bit n of spec_lines_o is set exactly when slot n holds a store. An access presented with the end strobe is not recorded.
- R7: An abort gives a one-cycle abort_o with spec_lines_o marking the write-set slots to discard. Abort takes priority over an end strobe in the same cycle. Both sets are empty afterwards, and spec_lines_o is zero in every cycle without a pulse.
- R8: While no transaction is active, accesses, snoops, events, end strobes and abort requests are ignored. No pulse results, and nothing is recorded that a later transaction could conflict on.
- R9: A begin strobe during an active transaction is ignored. The sets are kept and the transaction continues.
- R10: commit_o, abort_o, cause_o and spec_lines_o are registered. They respond in the cycle after the clock edge that sampled the deciding inputs. Snoops are compared against the sets as they stood before that edge's access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_begin_i | input | 1 | Start a transaction (ignored when active) |
| tx_end_i | input | 1 | Request commit |
| tx_abort_req_i | input | 1 | Explicit abort request |
| acc_valid_i | input | 1 | Local load or store present |
| acc_store_i | input | 1 | 1 = store, 0 = load |
| acc_line_i | input | LINE_W | Line number of the local access |
| snp_rd_i | input | 1 | Remote read snoop |
| snp_inv_i | input | 1 | Remote invalidation snoop |
| snp_line_i | input | LINE_W | Line number of the snoop |
| irq_i | input | 1 | Interrupt event |
| page_fault_i | input | 1 | Page-fault event |
| ctx_switch_i | input | 1 | Context-switch event |
| commit_o | output | 1 | One-cycle commit pulse |
| abort_o | output | 1 | One-cycle abort pulse |
| cause_o | output | 2 | 00 none, 01 conflict, 10 capacity, 11 system |
| spec_lines_o | output | CAPACITY | Slots holding speculative writes, valid with a pulse |

## Verification
The bench targets the conflict asymmetry. A remote read of a line that was only read must not abort, while a remote read of a written line must. A tracker that ignored the mark type would either abort falsely or let the write leak. The bench fills the table to exactly its capacity and then touches both an old line and a new one. An off-by-one in the full test either aborts one line early or lets a line past the limit. Several abort causes and an end strobe are stacked in single cycles to expose wrong priorities. Idle-time traffic and nested begins are followed by snoops on the same lines, and this exposes a tracker that records outside a transaction or restarts on a second begin.

// File: rtl/txn_line_tracker.sv
module txn_line_tracker #(
  parameter int LINE_W   = 26,
  parameter int CAPACITY = 512
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tx_begin_i,
  input  logic                tx_end_i,
  input  logic                tx_abort_req_i,
  input  logic                acc_valid_i,
  input  logic                acc_store_i,
  input  logic [LINE_W-1:0]   acc_line_i,
  input  logic                snp_rd_i,
  input  logic                snp_inv_i,
  input  logic [LINE_W-1:0]   snp_line_i,
  input  logic                irq_i,
  input  logic                page_fault_i,
  input  logic                ctx_switch_i,
  output logic                commit_o,
  output logic                abort_o,
  output logic [1:0]          cause_o,
  output logic [CAPACITY-1:0] spec_lines_o
);
  localparam int CNT_W = $clog2(CAPACITY + 1);

  logic              active_q;
  logic [CNT_W-1:0]  fill_q;
  logic [LINE_W-1:0] tag_q [CAPACITY];
  logic [CAPACITY-1:0] rd_q, wr_q;
  logic [CAPACITY-1:0] acc_hit, snp_conf;

  genvar i;
  generate
    for (i = 0; i < CAPACITY; i++) begin : g_slot
      logic valid, snp_match;
      assign valid       = CNT_W'(i) < fill_q;
      assign acc_hit[i]  = valid && (tag_q[i] == acc_line_i);
      assign snp_match   = valid && (tag_q[i] == snp_line_i);
      assign snp_conf[i] = snp_match &&
                           ((snp_inv_i && (rd_q[i] || wr_q[i])) || (snp_rd_i && wr_q[i]));
    end
  endgenerate

  logic sys_evt, conflict, any_hit, full, cap_ovf, kill, finish, record, alloc;
  assign sys_evt  = irq_i || page_fault_i || ctx_switch_i;
  assign conflict = |snp_conf;
  assign any_hit  = |acc_hit;
  assign full     = fill_q == CNT_W'(CAPACITY);
  assign cap_ovf  = acc_valid_i && !any_hit && full;
  assign kill     = active_q && (sys_evt || conflict || cap_ovf || tx_abort_req_i);
  assign finish   = active_q && (kill || tx_end_i);
  assign record   = active_q && acc_valid_i && !finish;
  assign alloc    = record && !any_hit;

  generate
    for (i = 0; i < CAPACITY; i++) begin : g_bits
      logic touch;
      assign touch = record && (acc_hit[i] || (!any_hit && fill_q == CNT_W'(i)));
      always_ff @(posedge clk) begin
        if (!rst_n || finish) begin
          rd_q[i] <= 1'b0;
          wr_q[i] <= 1'b0;
        end else if (touch) begin
          rd_q[i] <= rd_q[i] || !acc_store_i;
          wr_q[i] <= wr_q[i] || acc_store_i;
        end
      end
      always_ff @(posedge clk) begin
        if (touch) tag_q[i] <= acc_line_i;
      end
    end
  endgenerate

  logic [1:0] cause_d;
  assign cause_d = sys_evt  ? 2'b11 :
                   conflict ? 2'b01 :
                   cap_ovf  ? 2'b10 : 2'b00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q     <= 1'b0;
      fill_q       <= '0;
      commit_o     <= 1'b0;
      abort_o      <= 1'b0;
      cause_o      <= 2'b00;
      spec_lines_o <= '0;
    end else begin
      commit_o     <= finish && !kill;
      abort_o      <= kill;
      cause_o      <= kill ? cause_d : 2'b00;
      spec_lines_o <= finish ? wr_q : '0;
      if (finish) begin
        active_q <= 1'b0;
        fill_q   <= '0;
      end else begin
        if (tx_begin_i) active_q <= 1'b1;
        if (alloc)      fill_q   <= fill_q + CNT_W'(1);
      end
    end
  end
endmodule

module txn_line_tracker_chk #(
  parameter int CAPACITY = 512,
  parameter int CNT_W    = 10
) (
  input logic                clk,
  input logic                rst_n,
  input logic                active,
  input logic [CNT_W-1:0]    fill,
  input logic                sys_evt,
  input logic                commit,
  input logic                abort,
  input logic [1:0]          cause,
  input logic [CAPACITY-1:0] mask
);
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CNT_W'(CAPACITY)); // R4
  AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    !(commit && abort)); // R7
  AST_COMMIT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> cause == 2'b00); // R6
  AST_MASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(commit || abort) |-> mask == '0); // R7
  AST_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (commit || abort) |-> (fill == '0 && !active)); // R7
  AST_SYSTEM_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (active && sys_evt) |=> (abort && cause == 2'b11)); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !(commit || abort)); // R8
endmodule

bind txn_line_tracker txn_line_tracker_chk #(
  .CAPACITY(CAPACITY), .CNT_W($clog2(CAPACITY + 1))
) chk_i (
  .clk(clk), .rst_n(rst_n), .active(active_q), .fill(fill_q),
  .sys_evt(irq_i || page_fault_i || ctx_switch_i),
  .commit(commit_o), .abort(abort_o), .cause(cause_o), .mask(spec_lines_o)
);

// File: tb/txn_line_tracker_tb.sv
module txn_line_tracker_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LW  = 26;
  localparam int CAP = 512;

  logic clk = 0, rst_n = 0;
  logic tx_begin = 0, tx_end = 0, tx_abort = 0;
  logic acc_valid = 0, acc_store = 0, snp_rd = 0, snp_inv = 0;
  logic irq = 0, pf = 0, ctx = 0;
  logic [LW-1:0] acc_line = '0, snp_line = '0;
  logic commit, abort;
  logic [1:0] cause;
  logic [CAP-1:0] mask;

  txn_line_tracker #(.LINE_W(LW), .CAPACITY(CAP)) dut_i (
    .clk(clk), .rst_n(rst_n), .tx_begin_i(tx_begin), .tx_end_i(tx_end),
    .tx_abort_req_i(tx_abort), .acc_valid_i(acc_valid), .acc_store_i(acc_store),
    .acc_line_i(acc_line), .snp_rd_i(snp_rd), .snp_inv_i(snp_inv),
    .snp_line_i(snp_line), .irq_i(irq), .page_fault_i(pf), .ctx_switch_i(ctx),
    .commit_o(commit), .abort_o(abort), .cause_o(cause), .spec_lines_o(mask));

  always #(CLK_PERIOD/2) clk = ~clk;

  int tests = 0, fails = 0, cycles = 0;
  bit done = 0;

  // behavioural reference
  logic [LW-1:0] m_tag[$];
  bit m_rd[$], m_wr[$];
  bit m_act = 0;

  task automatic clear_inputs();
    tx_begin = 0; tx_end = 0; tx_abort = 0; acc_valid = 0; acc_store = 0;
    snp_rd = 0; snp_inv = 0; irq = 0; pf = 0; ctx = 0;
  endtask

  task automatic tick(string req);
    bit e_commit = 0, e_abort = 0, conf = 0, hit = 0;
    logic [1:0] e_cause = 2'b00;
    logic [CAP-1:0] e_mask = '0;
    int hidx = -1;
    if (m_act) begin
      foreach (m_tag[k]) begin
        if (acc_valid && m_tag[k] == acc_line) begin hit = 1; hidx = k; end
        if (m_tag[k] == snp_line && ((snp_inv && (m_rd[k] || m_wr[k])) || (snp_rd && m_wr[k])))
          conf = 1;
      end
      if (irq || pf || ctx) begin e_abort = 1; e_cause = 2'b11; end
      else if (conf) begin e_abort = 1; e_cause = 2'b01; end
      else if (acc_valid && !hit && m_tag.size() == CAP) begin e_abort = 1; e_cause = 2'b10; end
      else if (tx_abort) e_abort = 1;
      if (e_abort || tx_end) begin
        e_commit = !e_abort;
        foreach (m_wr[k]) e_mask[k] = m_wr[k];
        m_tag.delete(); m_rd.delete(); m_wr.delete(); m_act = 0;
      end else if (acc_valid) begin
        if (hit) begin
          if (acc_store) m_wr[hidx] = 1; else m_rd[hidx] = 1;
        end else begin
          m_tag.push_back(acc_line); m_rd.push_back(!acc_store); m_wr.push_back(acc_store);
        end
      end
    end else if (tx_begin) m_act = 1;
    @(posedge clk);
    @(negedge clk);
    tests++;
    if (commit !== e_commit || abort !== e_abort || cause !== e_cause || mask !== e_mask) begin
      fails++;
      $display("FAIL %s: commit=%b abort=%b cause=%b mask=%h expected commit=%b abort=%b cause=%b mask=%h",
               req, commit, abort, cause, mask, e_commit, e_abort, e_cause, e_mask);
    end
    clear_inputs();
  endtask

  task automatic access(bit st, logic [LW-1:0] ln, string req);
    acc_valid = 1; acc_store = st; acc_line = ln; tick(req);
  endtask

  task automatic snoop(bit inv, logic [LW-1:0] ln, string req);
    snp_inv = inv; snp_rd = !inv; snp_line = ln; tick(req);
  endtask

  task automatic start(string req);
    tx_begin = 1; tick(req);
  endtask

  task automatic finish_tx(string req);
    tx_end = 1; tick(req);
  endtask

  initial begin
    while (!done && cycles < 100000) begin @(posedge clk); cycles++; end
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected completion", cycles);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    tick("R7 reset state");

    // R8: idle traffic ignored
    access(1, 26'h100, "R8 idle store");
    tx_end = 1; tick("R8 idle end");
    tx_abort = 1; irq = 1; tick("R8 idle abort/irq");
    start("R8 begin");
    snoop(1, 26'h100, "R8 idle line not tracked");
    finish_tx("R8 empty commit");

    // R1, R3, R6
    start("R6 begin");
    access(0, 26'h0A0, "R1 load A");
    access(1, 26'h0B0, "R1 store B");
    access(0, 26'h0B0, "R1 load B same slot");
    access(1, 26'h0B0, "R1 store B again");
    snoop(0, 26'h0A0, "R3 remote read of read-only line");
    access(1, 26'h0C0, "R6 store C slot2");
    acc_valid = 1; acc_store = 1; acc_line = 26'h0D0; tx_end = 1;
    tick("R6 commit mask slots 1,2, access with end dropped");

    // R2 lock elision
    start("R2 begin");
    access(0, 26'h7FF, "R2 read lock word");
    access(1, 26'h010, "R2 store data");
    snoop(1, 26'h7FF, "R2 writer takes lock -> conflict");

    // R3 write-set remote read
    start("R3 begin");
    access(1, 26'h020, "R3 store");
    snoop(0, 26'h020, "R3 remote read of written line");

    // R5 + R7 priority over end
    start("R5 begin");
    access(1, 26'h030, "R5 store");
    access(1, 26'h031, "R5 store");
    irq = 1; tx_end = 1; snp_inv = 1; snp_line = 26'h030;
    tick("R5 irq beats conflict and end");
    start("R5 begin pf");
    pf = 1; tick("R5 page fault");
    start("R5 begin ctx");
    access(0, 26'h040, "R5 load");
    ctx = 1; tick("R5 context switch");

    // R9 nested begin
    start("R9 begin");
    access(0, 26'h050, "R9 load");
    start("R9 nested begin ignored");
    snoop(1, 26'h050, "R9 sets kept after nested begin");

    // R7 explicit abort, and conflict overriding it
    start("R7 begin");
    access(1, 26'h060, "R7 store");
    tx_abort = 1; tx_end = 1; tick("R7 explicit abort beats end");
    start("R7 begin2");
    access(0, 26'h061, "R7 load");
    tx_abort = 1; snp_inv = 1; snp_line = 26'h061; tick("R7 conflict cause over request");

    // R10: snoop on line being inserted this cycle sees old sets
    start("R10 begin");
    acc_valid = 1; acc_store = 1; acc_line = 26'h070; snp_rd = 1; snp_line = 26'h070;
    tick("R10 same-cycle snoop misses new line");
    snoop(0, 26'h070, "R10 next-cycle snoop hits");

    // R4 capacity
    start("R4 begin");
    for (int k = 0; k < CAP; k++) access(k[0], LW'(26'h1000 + k), "R4 fill");
    access(1, 26'h1005, "R4 tracked line at full");
    access(0, 26'h1005, "R4 tracked load at full");
    access(0, 26'h3FFF, "R4 new line over capacity");
    start("R4 begin2");
    for (int k = 0; k < CAP; k++) access(0, LW'(26'h2000 + k), "R4 fill2");
    acc_valid = 1; acc_line = 26'h9999; snp_inv = 1; snp_line = 26'h2003;
    tick("R4 conflict beats capacity");

    tick("R7 quiet");
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule